// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

The block decodes the 16-bit address of an 8-bit processor bus and turns it into wide physical addresses for an external program ROM and a battery-less work RAM. Writes aimed at the ROM address range never reach the ROM. They program a small set of control registers instead: a 9-bit ROM bank number, a 4-bit RAM bank number and a RAM enable. Reads of the lower 16 KiB always see ROM bank 0. Reads of the upper 16 KiB see whichever ROM bank is selected, and bank 0 may be chosen there too.

The 8 KiB window at 0xA000–0xBFFF reaches one of four RAM blocks while RAM is enabled. Bank codes 8 to 12 stand for timekeeping registers. This block only recognises those codes: a read returns zero and a write has no effect. All other states of the window read as an open bus (0xFF). Address, select and read-data outputs are combinational from the bus and the registers. The registers change only on a clock edge that has the write strobe high.

Top module: `cart_bank_mapper`

## Requirements
- R1: A read of 0x0000–0x3FFF asserts `rom_cs` and drives `rom_addr` = {9'h000, cpu_addr[13:0]}.
- R2: A read of 0x4000–0x7FFF drives `rom_addr` = {rom_bank[8:0], cpu_addr[13:0]}, that is bank × 0x4000 plus the offset, and `cpu_rdata` follows `rom_rdata`.
- R3: A write to 0x2000–0x2FFF loads the low 8 bank bits from the write data and keeps bank bit 8.
- R4: A write to 0x3000–0x3FFF loads bank bit 8 from data bit 0 and keeps the low 8 bank bits.
- R5: Bank value 0 in the switched window maps to physical ROM bank 0 and is not replaced by 1.
- R6: After reset the ROM bank is 1, the RAM bank is 0 and RAM is disabled.
- R7: A write to 0x0000–0x1FFF with data 0x0A enables RAM, data 0x00 disables it, and any other value leaves the enable unchanged.
- R8: A write to 0x4000–0x5FFF loads the RAM bank from data bits [3:0] and ignores bits [7:4].
- R9: With RAM enabled and RAM bank 0–3, an access to 0xA000–0xBFFF asserts `ram_cs`, asserts `ram_we` only on writes, drives `ram_addr` = {bank[1:0], cpu_addr[12:0]}, and on a read `cpu_rdata` follows `ram_rdata`.
- R10: With RAM enabled and RAM bank 8–12, a read of the RAM window returns 0x00, and both `ram_cs` and `ram_we` stay low on reads and writes.
- R11: With RAM disabled, or with RAM bank 4–7 or 13–15, `ram_cs` and `ram_we` stay low and a read of the RAM window returns 0xFF.
- R12: A write to 0x6000–0x7FFF, with data 0x00 or 0x01, changes neither bank register nor the RAM enable.
- R13: `rom_cs` is high only on reads below 0x8000. A read of 0x8000–0x9FFF or 0xC000–0xFFFF returns 0xFF with no select asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| rom_rdata | input | 8 | Data returned by the external ROM |
| ram_rdata | input | 8 | Data returned by the external RAM |
| rom_addr | output | 23 | Physical ROM byte address |
| ram_addr | output | 15 | Physical RAM byte address |
| rom_cs | output | 1 | ROM select |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Read data returned to the processor |

## Verification
The hardest state to reach is a split ROM bank value that is set only half-way, where one bank window has just been written and the other half must survive. Only a read of the switched window shows it. The stimulus drives the two halves in turn with opposite bit patterns, and it uses the first and last address of each window, so a decode that keeps the wrong half shows up in `rom_addr`. Timekeeping codes and out-of-range RAM codes are also walked at their edges (7, 8, 12, 13), both with RAM enabled and with RAM disabled.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Register window selected by the top address nibble of a write
  typedef enum logic [2:0] {
    WIN_RAM_EN,
    WIN_ROM_LO,
    WIN_ROM_HI,
    WIN_RAM_BANK,
    WIN_LATCH,
    WIN_NONE
  } cbm_win_e;

  localparam logic [7:0] RAM_KEY_ON  = 8'h0A;
  localparam logic [7:0] RAM_KEY_OFF = 8'h00;
  localparam logic [7:0] OPEN_BUS    = 8'hFF;
  localparam logic [7:0] CLK_READ    = 8'h00;
  localparam int         CLK_BANK_LO = 8;
  localparam int         CLK_BANK_HI = 12;
  localparam int         ROM_OFS_W   = 14;
  localparam int         RAM_OFS_W   = 13;

  function automatic cbm_win_e decode_win(input logic [3:0] nib);
    cbm_win_e w;
    casez (nib)
      4'b000?: w = WIN_RAM_EN;
      4'b0010: w = WIN_ROM_LO;
      4'b0011: w = WIN_ROM_HI;
      4'b010?: w = WIN_RAM_BANK;
      4'b011?: w = WIN_LATCH;
      default: w = WIN_NONE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cbm_rst_sync.sv
module cbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  cbm_win_e              win,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank_q,
  output logic [RAM_BANK_W-1:0] ram_bank_q,
  output logic                  ram_en_q
);

  localparam int ROM_HI_W = ROM_BANK_W - 8;

  logic [ROM_BANK_W-1:0] rom_bank_d;
  logic [RAM_BANK_W-1:0] ram_bank_d;
  logic                  ram_en_d;
  logic                  reg_ce;

  // Latch-command writes are accepted but touch no register
  assign reg_ce = wr_en && (win != WIN_NONE) && (win != WIN_LATCH);

  always_comb begin
    rom_bank_d = rom_bank_q;
    ram_bank_d = ram_bank_q;
    ram_en_d   = ram_en_q;
    unique case (win)
      WIN_RAM_EN: begin
        if (wdata == RAM_KEY_ON)       ram_en_d = 1'b1;
        else if (wdata == RAM_KEY_OFF) ram_en_d = 1'b0;
      end
      WIN_ROM_LO:   rom_bank_d[7:0]            = wdata;
      WIN_ROM_HI:   rom_bank_d[ROM_BANK_W-1:8] = wdata[ROM_HI_W-1:0];
      WIN_RAM_BANK: ram_bank_d                 = wdata[RAM_BANK_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank_q <= ROM_BANK_W'(1);
      ram_bank_q <= '0;
      ram_en_q   <= 1'b0;
    end else if (reg_ce) begin
      rom_bank_q <= rom_bank_d;
      ram_bank_q <= ram_bank_d;
      ram_en_q   <= ram_en_d;
    end
  end

endmodule

// File: rtl/cbm_map.sv
module cbm_map
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int RAM_SEL_W  = 2,
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_ADDR_W = RAM_SEL_W + RAM_OFS_W
) (
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic                  ram_en,
  input  logic [7:0]            rom_rdata,
  input  logic [7:0]            ram_rdata,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  output logic [RAM_ADDR_W-1:0] ram_addr,
  output logic                  rom_cs,
  output logic                  ram_cs,
  output logic                  ram_we,
  output logic [7:0]            cpu_rdata
);

  logic                  rom_area;
  logic [ROM_BANK_W-1:0] eff_bank;
  logic                  ram_win;
  logic                  data_bank;
  logic                  clk_bank;
  logic                  ram_hit;
  logic                  clk_hit;

  assign rom_area = !cpu_addr[15];
  assign eff_bank = cpu_addr[14] ? rom_bank : '0;
  assign rom_addr = {eff_bank, cpu_addr[ROM_OFS_W-1:0]};
  assign rom_cs   = rom_area && cpu_rd;

  assign ram_win   = (cpu_addr[15:13] == 3'b101);
  assign data_bank = ((ram_bank >> RAM_SEL_W) == '0);
  assign clk_bank  = (ram_bank >= RAM_BANK_W'(CLK_BANK_LO)) &&
                     (ram_bank <= RAM_BANK_W'(CLK_BANK_HI));
  assign ram_hit   = ram_win && ram_en && data_bank;
  assign clk_hit   = ram_win && ram_en && clk_bank;

  assign ram_addr = {ram_bank[RAM_SEL_W-1:0], cpu_addr[RAM_OFS_W-1:0]};
  assign ram_cs   = ram_hit && (cpu_rd || cpu_wr);
  assign ram_we   = ram_hit && cpu_wr;

  always_comb begin
    if (rom_area)     cpu_rdata = rom_rdata;
    else if (ram_hit) cpu_rdata = ram_rdata;
    else if (clk_hit) cpu_rdata = CLK_READ;
    else              cpu_rdata = OPEN_BUS;
  end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int RAM_SEL_W  = 2,
  parameter int RST_STAGES = 2,
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_ADDR_W = RAM_SEL_W + RAM_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [7:0]            rom_rdata,
  input  logic [7:0]            ram_rdata,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  output logic [RAM_ADDR_W-1:0] ram_addr,
  output logic                  rom_cs,
  output logic                  ram_cs,
  output logic                  ram_we,
  output logic [7:0]            cpu_rdata
);

  logic                  rst_sync_n;
  cbm_win_e              win;
  logic                  reg_wr;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_en;

  assign win    = decode_win(cpu_addr[15:12]);
  assign reg_wr = cpu_wr && !cpu_addr[15];

  cbm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  cbm_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr),
    .win        (win),
    .wdata      (cpu_wdata),
    .rom_bank_q (rom_bank),
    .ram_bank_q (ram_bank),
    .ram_en_q   (ram_en)
  );

  cbm_map #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .RAM_SEL_W  (RAM_SEL_W)
  ) u_map (
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: rtl/cbm_checks.sv
module cbm_checks #(
  parameter int ROM_BANK_W = 9,
  localparam int ROM_ADDR_W = ROM_BANK_W + 14,
  localparam int ROM_HI_W   = ROM_BANK_W - 8
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic                  cpu_rd,
  input logic                  cpu_wr,
  input logic [ROM_ADDR_W-1:0] rom_addr,
  input logic                  rom_cs,
  input logic                  ram_cs,
  input logic                  ram_we
);

  // R13
  rom_sel_read_only_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rom_cs |-> (cpu_rd && !cpu_addr[15]));

  // R9
  ram_we_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ram_we |-> (ram_cs && cpu_wr));

  // R1
  fixed_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rom_cs && !cpu_addr[14]) |-> (rom_addr[ROM_ADDR_W-1:14] == '0));

  // R3
  rom_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && cpu_addr[15:12] == 4'h2) |=>
      (!(cpu_rd && cpu_addr[15:14] == 2'b01) || rom_addr[21:14] == $past(cpu_wdata)));

  // R4
  rom_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && cpu_addr[15:12] == 4'h3) |=>
      (!(cpu_rd && cpu_addr[15:14] == 2'b01) ||
       rom_addr[ROM_ADDR_W-1:22] == $past(cpu_wdata[ROM_HI_W-1:0])));

  // R11
  ram_off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata == 8'h00) |=> (!ram_cs && !ram_we));

endmodule

bind cart_bank_mapper cbm_checks #(.ROM_BANK_W(ROM_BANK_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .rom_addr  (rom_addr),
  .rom_cs    (rom_cs),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we)
);

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;

  localparam real HALF_NS = 2.5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  rom_rdata;
  logic [7:0]  ram_rdata;
  logic [22:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_cs;
  logic        ram_cs;
  logic        ram_we;
  logic [7:0]  cpu_rdata;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  // Simple memory models: data is a function of the physical address
  assign rom_rdata = rom_addr[7:0] ^ 8'h5A;
  assign ram_rdata = ram_addr[7:0] ^ 8'hC3;

  always #(HALF_NS) clk = ~clk;

  cart_bank_mapper u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write cycle; the strobe is seen by the rising edge in the middle
  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d,
                        output logic cs_o, output logic we_o, output logic rcs_o);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
    #1;
    cs_o = ram_cs; we_o = ram_we; rcs_o = rom_cs;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic c, w, r;
    bus_wr(a, d, c, w, r);
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
  endtask

  task automatic rd_rom(input string req, input logic [15:0] a, input logic [8:0] bank);
    logic [22:0] exp;
    rd(a);
    exp = a[14] ? {bank, a[13:0]} : {9'd0, a[13:0]};
    chk({req, " rom_addr"}, 32'(rom_addr), 32'(exp));
    chk({req, " rom_cs"}, 32'(rom_cs), 32'd1);
    chk({req, " rdata"}, 32'(cpu_rdata), 32'(exp[7:0] ^ 8'h5A));
  endtask

  task automatic t_reset;
    rd_rom("R6 rom bank 1", 16'h4123, 9'h001);
    rd(16'hA010);
    chk("R6 ram off cs", 32'(ram_cs), 32'd0);
    chk("R6 ram off rdata", 32'(cpu_rdata), 32'hFF);
    wr(16'h4000, 8'h00);   // bank 0 is the reset value: enabling alone must give data access
    wr(16'h0000, 8'h0A);
    rd(16'hA010);
    chk("R6 ram bank 0 addr", 32'(ram_addr), 32'h0010);
    wr(16'h0000, 8'h00);
  endtask

  task automatic t_fixed;
    logic c, w, r;
    rd_rom("R1 low window", 16'h3ABC, 9'h0);
    rd_rom("R1 first byte", 16'h0000, 9'h0);
    bus_wr(16'h7000, 8'h00, c, w, r);
    chk("R13 no rom_cs on write", 32'(r), 32'd0);
  endtask

  task automatic t_rom_bank;
    wr(16'h2000, 8'h35);
    rd_rom("R2 bank 0x035", 16'h4001, 9'h035);
    wr(16'h3000, 8'h01);
    rd_rom("R4 set bit8", 16'h7FFF, 9'h135);
    wr(16'h2FFF, 8'hC2);
    rd_rom("R3 keep bit8", 16'h4000, 9'h1C2);
    wr(16'h3FFF, 8'hFE);
    rd_rom("R4 clear bit8 keep low", 16'h5555, 9'h0C2);
    rd_rom("R1 fixed unaffected", 16'h1234, 9'h0);
  endtask

  task automatic t_bank0;
    wr(16'h2000, 8'h00);
    wr(16'h3000, 8'h00);
    rd_rom("R5 bank zero", 16'h4055, 9'h000);
  endtask

  task automatic t_ram;
    logic c, w, r;
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'hF2);
    rd(16'hA123);
    chk("R8 R9 ram_cs", 32'(ram_cs), 32'd1);
    chk("R8 R9 ram_addr", 32'(ram_addr), 32'h4123);
    chk("R9 ram_we on read", 32'(ram_we), 32'd0);
    chk("R9 rdata", 32'(cpu_rdata), 32'(8'h23 ^ 8'hC3));
    bus_wr(16'hBFFF, 8'h77, c, w, r);
    chk("R9 write cs", 32'(c), 32'd1);
    chk("R9 write we", 32'(w), 32'd1);
    wr(16'h5FFF, 8'h03);
    rd(16'hB000);
    chk("R8 bank 3 addr", 32'(ram_addr), 32'h7000);
  endtask

  task automatic t_enable;
    wr(16'h1FFF, 8'h55);
    rd(16'hA000);
    chk("R7 other value keeps on", 32'(ram_cs), 32'd1);
    wr(16'h0100, 8'h00);
    rd(16'hA000);
    chk("R7 R11 off cs", 32'(ram_cs), 32'd0);
    chk("R11 off rdata", 32'(cpu_rdata), 32'hFF);
    wr(16'h0000, 8'h0B);
    rd(16'hA000);
    chk("R7 other value keeps off", 32'(ram_cs), 32'd0);
    wr(16'h0000, 8'h0A);
    rd(16'hA000);
    chk("R7 on again", 32'(ram_cs), 32'd1);
  endtask

  task automatic t_clock;
    logic c, w, r;
    wr(16'h5000, 8'h09);
    rd(16'hA000);
    chk("R10 clock read data", 32'(cpu_rdata), 32'h00);
    chk("R10 clock read cs", 32'(ram_cs), 32'd0);
    bus_wr(16'hA000, 8'h44, c, w, r);
    chk("R10 clock write we", 32'(w), 32'd0);
    chk("R10 clock write cs", 32'(c), 32'd0);
    wr(16'h4000, 8'h08);
    rd(16'hA001);
    chk("R10 code 8", 32'(cpu_rdata), 32'h00);
    wr(16'h4000, 8'h0C);
    rd(16'hBFFF);
    chk("R10 code 12", 32'(cpu_rdata), 32'h00);
    wr(16'h4000, 8'h0D);
    rd(16'hA000);
    chk("R11 code 13 data", 32'(cpu_rdata), 32'hFF);
    wr(16'h4000, 8'h07);
    bus_wr(16'hA000, 8'h11, c, w, r);
    chk("R11 code 7 we", 32'(w), 32'd0);
    rd(16'hA000);
    chk("R11 code 7 data", 32'(cpu_rdata), 32'hFF);
    chk("R11 code 7 cs", 32'(ram_cs), 32'd0);
    wr(16'h0000, 8'h00);
    wr(16'h4000, 8'h0A);
    rd(16'hA000);
    chk("R11 clock code while off", 32'(cpu_rdata), 32'hFF);
  endtask

  task automatic t_latch;
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h01);
    wr(16'h2000, 8'h5A);
    wr(16'h3000, 8'h01);
    wr(16'h6000, 8'h01);
    wr(16'h7FFF, 8'h00);
    rd_rom("R12 rom bank kept", 16'h4000, 9'h15A);
    rd(16'hA002);
    chk("R12 ram kept cs", 32'(ram_cs), 32'd1);
    chk("R12 ram bank kept", 32'(ram_addr), 32'h2002);
  endtask

  task automatic t_unmapped;
    rd(16'h8000);
    chk("R13 0x8000 data", 32'(cpu_rdata), 32'hFF);
    chk("R13 0x8000 rom_cs", 32'(rom_cs), 32'd0);
    chk("R13 0x8000 ram_cs", 32'(ram_cs), 32'd0);
    rd(16'hC000);
    chk("R13 0xC000 data", 32'(cpu_rdata), 32'hFF);
    chk("R13 0xC000 rom_cs", 32'(rom_cs), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fixed();
    t_rom_bank();
    t_bank0();
    t_ram();
    t_enable();
    t_clock();
    t_latch();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(HALF_NS * 2 * 20000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule